// File: doc/BRIEF.md
# Bidirectional Register List Sequencer

This block walks a 16-entry register-selection mask of the kind carried by block load and block store operations. After a start pulse it captures the mask and hands out the indices of the set bits, one per accepted cycle, through a valid/ready handshake. Each step takes its index from the low end or from the high end of what remains, chosen by a direction input sampled on that step. The unit that computes addresses and moves data consumes the indices in the order it needs.

Two cursors bound the part of the captured mask that has not been handed out yet. An ascending step consumes the lowest remaining set bit and moves the lower cursor just past it. A descending step consumes the highest remaining set bit and moves the upper cursor just below it. Because both ends shrink the same window, ascending and descending steps can be mixed freely and no index is handed out twice.

Alongside the walk, the block decodes the live mask input combinationally. It gives an empty flag, the number of set bits, the lowest set index, and one flag each for the stack-pointer, link and program-counter slots.

Top module: `reglist_walker`

## Requirements
- R1: While reset is held and after it is released with no start, valid_o and done_o are 0.
- R2: Bit i of the mask selects register i. With dir_down_i = 0 on every step, the indices come out in ascending order. Mask 0xAAAA gives 1, 3, 5, 7, 9, 11, 13, 15.
- R3: With dir_down_i = 1 on every step, the indices come out in descending order. Mask 0xAAAA gives 15, 13, 11, 9, 7, 5, 3, 1.
- R4: Ascending and descending steps may be interleaved. The lower end then yields the lowest remaining index and the upper end yields the highest. Every set bit comes out exactly once.
- R5: valid_o is high while the active walk still holds an unconsumed set bit. An index is consumed on each clock edge where valid_o and ready_i are both high. With ready_i low, valid_o stays high and, for an unchanged direction, index_o is held. Clear mask positions cost no cycles.
- R6: done_o is high for exactly one cycle, the cycle after the last index is consumed, and valid_o is low in that cycle. For an all-zero mask, done_o is high in the cycle after the start pulse.
- R7: A start pulse reloads the mask and resets both cursors (lower to 0, upper to 15), even in the middle of a walk.
- R8: count_o equals the number of set bits of mask_i, and empty_o is 1 exactly when mask_i is zero.
- R9: lowest_o is the position of the lowest set bit of mask_i, and 0 when mask_i is zero.
- R10: has_sp_o, has_lr_o and has_pc_o equal mask_i bits 13, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture mask_i and begin a new walk |
| mask_i | input | 16 | Register-selection mask, bit i selects register i |
| dir_down_i | input | 1 | Step direction: 0 takes from the low end, 1 from the high end |
| ready_i | input | 1 | Consumer accepts index_o this cycle |
| valid_o | output | 1 | index_o holds an unconsumed index |
| index_o | output | 4 | Index offered for the current direction |
| done_o | output | 1 | One-cycle pulse once the walk is exhausted |
| empty_o | output | 1 | mask_i has no set bit |
| count_o | output | 5 | Number of set bits in mask_i |
| lowest_o | output | 4 | Lowest set position in mask_i (0 if empty) |
| has_sp_o | output | 1 | mask_i bit 13 |
| has_lr_o | output | 1 | mask_i bit 14 |
| has_pc_o | output | 1 | mask_i bit 15 |

## Verification
The hold and stability properties apply only when start_i is low, and the index-stability check only when dir_down_i is unchanged across the stalled cycle. This is because the direction input legitimately changes which end is offered. The bench drives every input at the falling edge from known values after reset. It toggles dir_down_i and ready_i at will, including during stalls, so those properties are reached in both their guarded and their excluded cases. Start pulses are issued both from idle and in the middle of a walk.

// File: rtl/reglist_pkg.sv
package reglist_pkg;

   typedef enum logic {
      STEP_UP   = 1'b0,
      STEP_DOWN = 1'b1
   } step_dir_e;

   function automatic int unsigned ones_in(input logic [63:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < n; i++) begin
         if (v[i]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/reglist_prienc.sv
module reglist_prienc #(
   parameter int unsigned NREG      = 16,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NREG-1:0]         vec_i,
   output logic [$clog2(NREG)-1:0] idx_o
);
   localparam int unsigned IDX_W = $clog2(NREG);

   if (NREG < 2) begin : g_bad_nreg
      $error("reglist_prienc: NREG must be at least 2");
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx_o = '0;
         for (int i = NREG - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NREG; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/reglist_summary.sv
module reglist_summary #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned SP_POS = 13,
   parameter int unsigned LR_POS = 14,
   parameter int unsigned PC_POS = 15
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NREG-1:0]           mask_i,
   output logic                      empty_o,
   output logic [$clog2(NREG+1)-1:0] count_o,
   output logic [$clog2(NREG)-1:0]   lowest_o,
   output logic                      has_sp_o,
   output logic                      has_lr_o,
   output logic                      has_pc_o
);
   import reglist_pkg::*;
   localparam int unsigned CNT_W = $clog2(NREG + 1);

   if (SP_POS >= NREG || LR_POS >= NREG || PC_POS >= NREG) begin : g_bad_pos
      $error("reglist_summary: special slot positions must lie inside the mask");
   end
   if (NREG > 64) begin : g_bad_width
      $error("reglist_summary: NREG above 64 is not supported");
   end

   always_comb begin
      count_o = CNT_W'(ones_in(64'(mask_i), NREG));
   end

   assign empty_o  = (mask_i == '0);
   assign has_sp_o = mask_i[SP_POS];
   assign has_lr_o = mask_i[LR_POS];
   assign has_pc_o = mask_i[PC_POS];

   reglist_prienc #(.NREG(NREG), .LOW_FIRST(1'b1)) u_low (
      .vec_i (mask_i),
      .idx_o (lowest_o)
   );

   // R8: population count and empty flag agree
   a_r8_empty_count : assert property (@(posedge clk) disable iff (!rst_n)
      empty_o == (count_o == '0));
   // R9: reported lowest position is really set
   a_r9_lowest_set : assert property (@(posedge clk) disable iff (!rst_n)
      !empty_o |-> mask_i[lowest_o]);
endmodule

// File: rtl/reglist_walker.sv
module reglist_walker #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned SP_POS = 13,
   parameter int unsigned LR_POS = 14,
   parameter int unsigned PC_POS = 15
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [NREG-1:0]           mask_i,
   input  logic                      dir_down_i,
   input  logic                      ready_i,
   output logic                      valid_o,
   output logic [$clog2(NREG)-1:0]   index_o,
   output logic                      done_o,
   output logic                      empty_o,
   output logic [$clog2(NREG+1)-1:0] count_o,
   output logic [$clog2(NREG)-1:0]   lowest_o,
   output logic                      has_sp_o,
   output logic                      has_lr_o,
   output logic                      has_pc_o
);
   import reglist_pkg::*;
   localparam int unsigned IDX_W = $clog2(NREG);
   localparam int unsigned CUR_W = $clog2(NREG + 1);

   if (NREG < 2) begin : g_bad_nreg
      $error("reglist_walker: NREG must be at least 2");
   end

   logic [NREG-1:0]  mask_q;
   logic [CUR_W-1:0] lo_q;      // lower cursor
   logic [CUR_W-1:0] hi_excl_q; // upper cursor plus one
   logic             active_q;
   logic [NREG-1:0]  live;
   logic             any_live;
   logic [IDX_W-1:0] up_idx, down_idx;
   logic             fire;
   step_dir_e        step_dir;

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         live[i] = mask_q[i] && (CUR_W'(i) >= lo_q) && (CUR_W'(i) < hi_excl_q);
      end
   end

   assign any_live = |live;
   assign step_dir = step_dir_e'(dir_down_i);

   reglist_prienc #(.NREG(NREG), .LOW_FIRST(1'b1)) u_up (
      .vec_i (live),
      .idx_o (up_idx)
   );
   reglist_prienc #(.NREG(NREG), .LOW_FIRST(1'b0)) u_down (
      .vec_i (live),
      .idx_o (down_idx)
   );

   assign valid_o = active_q && any_live;
   assign done_o  = active_q && !any_live;
   assign index_o = (step_dir == STEP_DOWN) ? down_idx : up_idx;
   assign fire    = valid_o && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         lo_q      <= '0;
         hi_excl_q <= '0;
         active_q  <= 1'b0;
      end else if (start_i) begin
         mask_q    <= mask_i;
         lo_q      <= '0;
         hi_excl_q <= CUR_W'(NREG);
         active_q  <= 1'b1;
      end else if (done_o) begin
         active_q  <= 1'b0;
      end else if (fire) begin
         if (step_dir == STEP_DOWN) hi_excl_q <= CUR_W'(down_idx);
         else                       lo_q      <= CUR_W'(up_idx) + CUR_W'(1);
      end
   end

   reglist_summary #(
      .NREG(NREG), .SP_POS(SP_POS), .LR_POS(LR_POS), .PC_POS(PC_POS)
   ) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (mask_i),
      .empty_o  (empty_o),
      .count_o  (count_o),
      .lowest_o (lowest_o),
      .has_sp_o (has_sp_o),
      .has_lr_o (has_lr_o),
      .has_pc_o (has_pc_o)
   );

   // R4: a consumed index is never offered again in the same walk
   a_r4_no_repeat : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !start_i) |=> !(valid_o && index_o == $past(index_o)));
   // R5: a stalled offer stays offered
   a_r5_hold_valid : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i && !start_i) |=> valid_o);
   // R5: a stalled offer keeps its index while the direction is unchanged
   a_r5_hold_index : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i && !start_i) ##1 $stable(dir_down_i) |-> $stable(index_o));
   // R6: done and valid are exclusive
   a_r6_done_excl : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);
   // R6: done lasts a single cycle
   a_r6_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
endmodule

// File: tb/reglist_walker_tb.sv
`timescale 1ns/1ps
module reglist_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] mask_i = '0;
   logic        dir_down_i = 1'b0;
   logic        ready_i = 1'b0;
   logic        valid_o, done_o, empty_o, has_sp_o, has_lr_o, has_pc_o;
   logic [3:0]  index_o, lowest_o;
   logic [4:0]  count_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // behavioural model state
   int m_mask = 0;
   int m_lo = 0;
   int m_hi = 15;
   bit m_active = 1'b0;
   int got[$];

   always #2.5 clk = ~clk;

   reglist_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
      .dir_down_i(dir_down_i), .ready_i(ready_i), .valid_o(valid_o),
      .index_o(index_o), .done_o(done_o), .empty_o(empty_o),
      .count_o(count_o), .lowest_o(lowest_o), .has_sp_o(has_sp_o),
      .has_lr_o(has_lr_o), .has_pc_o(has_pc_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int find_low();
      for (int i = m_lo; i <= m_hi; i++) if (m_mask[i]) return i;
      return -1;
   endfunction

   function automatic int find_high();
      for (int i = m_hi; i >= m_lo; i--) if (m_mask[i]) return i;
      return -1;
   endfunction

   // one clock: drive, compare, advance the model
   task automatic cyc(input bit st, input logic [15:0] mk, input bit dn, input bit rd);
      int lo_i, hi_i, exp_idx, pc, low_exp;
      bit exp_valid;
      start_i = st; mask_i = mk; dir_down_i = dn; ready_i = rd;
      #1;
      lo_i = find_low();
      hi_i = find_high();
      exp_valid = m_active && (lo_i >= 0);
      exp_idx = dn ? hi_i : lo_i;
      chk("R5", "valid", int'(valid_o), int'(exp_valid));
      chk("R6", "done", int'(done_o), int'(m_active && lo_i < 0));
      if (exp_valid) chk(dn ? "R3" : "R2", "index", int'(index_o), exp_idx);
      pc = 0; low_exp = -1;
      for (int i = 0; i < 16; i++) if (mk[i]) begin pc++; if (low_exp < 0) low_exp = i; end
      if (low_exp < 0) low_exp = 0;
      chk("R8", "count", int'(count_o), pc);
      chk("R8", "empty", int'(empty_o), int'(mk == 16'h0));
      chk("R9", "lowest", int'(lowest_o), low_exp);
      chk("R10", "sp/lr/pc", int'({has_sp_o, has_lr_o, has_pc_o}), int'({mk[13], mk[14], mk[15]}));
      if (valid_o && rd && !st) got.push_back(int'(index_o));
      @(posedge clk);
      if (st) begin
         m_mask = int'(mk); m_lo = 0; m_hi = 15; m_active = 1'b1;
      end else if (m_active && lo_i < 0) begin
         m_active = 1'b0;
      end else if (exp_valid && rd) begin
         if (dn) m_hi = exp_idx - 1;
         else    m_lo = exp_idx + 1;
      end
      @(negedge clk);
   endtask

   task automatic run_walk(input logic [15:0] mk, input bit dn);
      got.delete();
      cyc(1'b1, mk, dn, 1'b1);
      for (int k = 0; k < 20; k++) begin
         if (!m_active) break;
         cyc(1'b0, mk, dn, 1'b1);
      end
   endtask

   task automatic final_report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         final_report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", int'(valid_o), 0);
      chk("R1", "done in reset", int'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(1'b0, 16'h2000, 1'b0, 1'b1); // R1 idle after reset, R10 sp
      cyc(1'b0, 16'h4000, 1'b0, 1'b1);
      cyc(1'b0, 16'h8000, 1'b1, 1'b1);

      // R2 ascending walk of 0xAAAA
      run_walk(16'hAAAA, 1'b0);
      chk("R2", "ascending length", got.size(), 8);
      foreach (got[k]) chk("R2", "ascending order", got[k], 2 * k + 1);

      // R3 descending walk of 0xAAAA
      run_walk(16'hAAAA, 1'b1);
      chk("R3", "descending length", got.size(), 8);
      foreach (got[k]) chk("R3", "descending order", got[k], 15 - 2 * k);

      // R4 alternating ends over 0xF0F1
      got.delete();
      cyc(1'b1, 16'hF0F1, 1'b0, 1'b1);
      for (int k = 0; k < 12; k++) cyc(1'b0, 16'hF0F1, k[0], 1'b1);
      begin
         int exp_seq[9] = '{0, 15, 4, 14, 5, 13, 6, 12, 7};
         chk("R4", "mixed length", got.size(), 9);
         foreach (exp_seq[k]) if (k < got.size()) chk("R4", "mixed order", got[k], exp_seq[k]);
      end

      // R5 stalls with direction changes
      got.delete();
      cyc(1'b1, 16'h1234, 1'b0, 1'b0);
      for (int k = 0; k < 24; k++) cyc(1'b0, 16'h1234, (k % 5) == 3, (k % 3) != 1);
      chk("R5", "stalled walk count", got.size(), 5);

      // R6 empty mask
      cyc(1'b1, 16'h0000, 1'b0, 1'b1);
      chk("R6", "done after empty start", int'(done_o), 1);
      cyc(1'b0, 16'h0000, 1'b0, 1'b1);
      cyc(1'b0, 16'h0000, 1'b0, 1'b1);

      // R7 restart in the middle of a walk
      got.delete();
      cyc(1'b1, 16'hFFFF, 1'b0, 1'b1);
      cyc(1'b0, 16'hFFFF, 1'b0, 1'b1);
      cyc(1'b0, 16'hFFFF, 1'b1, 1'b1);
      cyc(1'b1, 16'h0300, 1'b0, 1'b1);
      chk("R7", "first after restart up", int'(index_o), 8);
      dir_down_i = 1'b1; #0.5;
      chk("R7", "first after restart down", int'(index_o), 9);
      for (int k = 0; k < 4; k++) cyc(1'b0, 16'h0300, 1'b0, 1'b1);

      // random walks
      for (int r = 0; r < 40; r++) begin
         logic [15:0] mk;
         mk = 16'($urandom);
         if (r % 7 == 0) mk = mk & 16'($urandom);
         cyc(1'b1, mk, 1'b0, 1'b1);
         for (int k = 0; k < 40; k++) begin
            if (!m_active) break;
            cyc(1'b0, mk ^ 16'($urandom), 1'($urandom), 1'($urandom));
         end
      end

      finished = 1'b1;
      final_report();
   end
endmodule